// File: doc/BRIEF.md
# Prioritized Timer Interrupt Latch

This block takes single-cycle maxcount event pulses from three timers and presents one shared interrupt request line to the processor. Each timer has a pending flag, an enable input and a vector number of its own. An event sets its source's flag only while that source's enable is high. Once a flag is set, it stays set until that source is acknowledged. Dropping the enable later does not clear it.

When the processor acknowledges, the block picks the pending source with the highest priority. Timer 0 ranks highest and timer 2 lowest. The block clears that source's flag at the acknowledge edge and presents its vector for exactly one cycle. A source that fires again while it is still pending produces no second request, because the new event merges into the one already latched.

Top module: `tmr_irq_latch`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every pending flag is clear, `irqOut` is low and `vecValid` is low.
- R2: An `evtIn[i]` pulse sampled while `intEn[i]` is 1 sets source i's pending flag at that clock edge.
- R3: An `evtIn[i]` pulse sampled while `intEn[i]` is 0 leaves source i's pending state unchanged. No later acknowledge returns its vector.
- R4: Clearing `intEn[i]` after source i is pending does not cancel the request. The request stays until it is acknowledged.
- R5: Several events from one source before it is acknowledged yield one pending request. One acknowledge returns its vector once, and the next acknowledge does not return it again.
- R6: `irqOut` is high exactly when at least one pending flag is set, starting in the cycle after the edge that changed the flags.
- R7: An `ackIn` sampled high while any flag is pending selects the lowest-indexed pending source (index 0 is highest priority). In the next cycle, `vecValid` is 1 for one cycle and `vecOut` equals `VEC_BASE + i*VEC_STRIDE`, which is 0x20 + i with the default parameters.
- R8: An acknowledge clears only the selected source's flag, and other pending flags are kept.
- R9: If an enabled event on the selected source arrives in the same cycle as its acknowledge, the vector is returned and the flag stays set.
- R10: An acknowledge while nothing is pending leaves `vecValid` low and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtIn | input | 3 | Per-timer maxcount event pulse, bit i for timer i |
| intEn | input | 3 | Per-timer interrupt enable level |
| ackIn | input | 1 | Interrupt acknowledge strobe |
| irqOut | output | 1 | Shared interrupt request |
| vecValid | output | 1 | One-cycle qualifier for `vecOut` after an acknowledge |
| vecOut | output | VEC_W | Vector number of the acknowledged source |

## Verification
The bench sweeps every combination of event and enable masks. After each one, it drains the pending set through acknowledges and checks that vectors arrive in ascending source order with `irqOut` tracking what is left.

- A design that inverted the priority would return the vectors in the wrong order.
- A design that cleared every flag on one acknowledge would drop the lower sources.
- A design that queued repeated events would return one vector twice.
- A design that let the enable gate the held flag would lose a request when the enable is dropped.
- A design that gave the clear priority over a simultaneous event would lose the event that arrived in the acknowledge cycle.
- A design that asserted `vecValid` on an acknowledge with nothing pending would deliver a spurious vector.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  parameter int SRC_N = 3;
  parameter int IDX_W = (SRC_N > 1) ? $clog2(SRC_N) : 1;

  // Strobes from the selection logic to the latch datapath
  typedef struct packed {
    logic             grant;
    logic [SRC_N-1:0] clrMask;
    logic [IDX_W-1:0] grantIdx;
  } ctrlStrobe_t;
endpackage

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tmr_irq_pkg::*;
(
  input  logic             ackIn,
  input  logic [SRC_N-1:0] pendQ,
  output ctrlStrobe_t      strb
);
  logic [SRC_N:0]   blocked;
  logic [SRC_N-1:0] winner;
  logic [IDX_W-1:0] idx;

  assign blocked[0] = 1'b0;

  // Fixed priority chain: lower index wins
  generate
    for (genvar i = 0; i < SRC_N; i++) begin : gChain
      assign winner[i]    = pendQ[i] & ~blocked[i];
      assign blocked[i+1] = blocked[i] | pendQ[i];
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (pendQ[i]) idx = IDX_W'(i);
    end
  end

  always_comb begin
    strb.grant    = ackIn & blocked[SRC_N];
    strb.clrMask  = winner & {SRC_N{ackIn}};
    strb.grantIdx = idx;
  end
endmodule

// File: rtl/tmr_irq_dp.sv
module tmr_irq_dp
  import tmr_irq_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'h20,
  parameter int VEC_STRIDE = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SRC_N-1:0] evtIn,
  input  logic [SRC_N-1:0] intEn,
  input  ctrlStrobe_t      strb,
  output logic [SRC_N-1:0] pendQ,
  output logic             vecValid,
  output logic [VEC_W-1:0] vecOut
);
  logic [SRC_N-1:0] setMask;
  logic [VEC_W-1:0] vecNext;

  assign setMask = evtIn & intEn;
  assign vecNext = VEC_BASE + VEC_W'(strb.grantIdx) * VEC_W'(VEC_STRIDE);

  generate
    for (genvar i = 0; i < SRC_N; i++) begin : gPend
      // A new event wins over a clear in the same cycle
      always_ff @(posedge clk) begin
        if (!rstN) pendQ[i] <= 1'b0;
        else       pendQ[i] <= (pendQ[i] & ~strb.clrMask[i]) | setMask[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecValid <= 1'b0;
      vecOut   <= '0;
    end else begin
      vecValid <= strb.grant;
      if (strb.grant) vecOut <= vecNext;
    end
  end
endmodule

// File: rtl/tmr_irq_latch.sv
module tmr_irq_latch
  import tmr_irq_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'h20,
  parameter int VEC_STRIDE = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       evtIn,
  input  logic [2:0]       intEn,
  input  logic             ackIn,
  output logic             irqOut,
  output logic             vecValid,
  output logic [VEC_W-1:0] vecOut
);
  ctrlStrobe_t      strb;
  logic [SRC_N-1:0] pendQ;

  tmr_irq_ctrl uCtrl (
    .ackIn (ackIn),
    .pendQ (pendQ),
    .strb  (strb)
  );

  tmr_irq_dp #(
    .VEC_W     (VEC_W),
    .VEC_BASE  (VEC_BASE),
    .VEC_STRIDE(VEC_STRIDE)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .evtIn   (evtIn),
    .intEn   (intEn),
    .strb    (strb),
    .pendQ   (pendQ),
    .vecValid(vecValid),
    .vecOut  (vecOut)
  );

  assign irqOut = |pendQ;
endmodule

// File: rtl/tmr_irq_chk.sv
module tmr_irq_chk
  import tmr_irq_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'h20,
  parameter int VEC_STRIDE = 1
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       evtIn,
  input logic [2:0]       intEn,
  input logic             ackIn,
  input logic             irqOut,
  input logic             vecValid,
  input logic [VEC_W-1:0] vecOut,
  input logic [SRC_N-1:0] pendQ
);
  function automatic logic [VEC_W-1:0] expVec(input logic [SRC_N-1:0] p);
    logic [VEC_W-1:0] v;
    v = '0;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (p[i]) v = VEC_BASE + VEC_W'(i) * VEC_W'(VEC_STRIDE);
    end
    return v;
  endfunction

  AST_RESET_QUIET: assert property (@(posedge clk) !rstN |=> (!irqOut && !vecValid)); // R1

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendQ & $past(evtIn & intEn)) == $past(evtIn & intEn))); // R2

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendQ & ~$past(pendQ) & ~$past(evtIn & intEn)) == '0)); // R3

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !ackIn) |=> irqOut); // R4

  AST_GRANT_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> ($past(ackIn) && ($past(pendQ) != '0))); // R10

  AST_PRIO_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && (pendQ != '0)) |=> (vecValid && vecOut == expVec($past(pendQ)))); // R7

  AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    ackIn |=> ($countones($past(pendQ) & ~pendQ) <= 1)); // R8
endmodule

bind tmr_irq_latch tmr_irq_chk #(
  .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
) uChk (
  .clk(clk), .rstN(rstN), .evtIn(evtIn), .intEn(intEn), .ackIn(ackIn),
  .irqOut(irqOut), .vecValid(vecValid), .vecOut(vecOut), .pendQ(pendQ)
);

// File: tb/sim_tmr_irq_latch.sv
module sim_tmr_irq_latch;
  localparam int VEC_W = 8;
  localparam logic [7:0] VBASE = 8'h20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] evtIn = '0;
  logic [2:0] intEn = '0;
  logic       ackIn = 1'b0;
  logic       irqOut;
  logic       vecValid;
  logic [7:0] vecOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmr_irq_latch u0 (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .intEn(intEn), .ackIn(ackIn),
    .irqOut(irqOut), .vecValid(vecValid), .vecOut(vecOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Apply inputs for one edge, then sample at the next falling edge
  task automatic step(input logic [2:0] ev, input logic ak);
    evtIn = ev;
    ackIn = ak;
    @(posedge clk);
    @(negedge clk);
    evtIn = '0;
    ackIn = 1'b0;
  endtask

  // Drain an expected pending set by acknowledges
  task automatic drain(input logic [2:0] m, input string req);
    logic [2:0] rem;
    rem = m;
    for (int k = 0; k < 3; k++) begin
      if (rem != 0) begin
        int lo;
        lo = 0;
        for (int b = 2; b >= 0; b--) if (rem[b]) lo = b;
        step(3'b000, 1'b1);
        rem[lo] = 1'b0;
        chk({req, " R7 valid"}, vecValid, 1);
        chk({req, " R7 vector"}, vecOut, VBASE + lo);
        chk({req, " R6/R8 irq"}, irqOut, rem != 0);
      end
    end
    step(3'b000, 1'b1);
    chk({req, " R10 empty ack"}, vecValid, 0);
    chk({req, " R10 irq"}, irqOut, 0);
  endtask

  initial begin
    @(negedge clk);
    chk("R1 reset irq", irqOut, 0);
    chk("R1 reset valid", vecValid, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 post-reset irq", irqOut, 0);

    // Exhaustive sweep over enable and event masks: R2, R3, R6, R7, R8
    for (int en = 0; en < 8; en++) begin
      for (int ev = 0; ev < 8; ev++) begin
        intEn = 3'(en);
        step(3'(ev), 1'b0);
        chk("R2/R3/R6 irq after event", irqOut, (ev & en) != 0);
        intEn = '0;
        drain(3'(ev & en), "sweep");
      end
    end

    // R4: enable dropped after latching
    intEn = 3'b010;
    step(3'b010, 1'b0);
    intEn = '0;
    step(3'b000, 1'b0);
    step(3'b000, 1'b0);
    chk("R4 still pending", irqOut, 1);
    drain(3'b010, "R4");

    // R5: repeated events merge into one request
    intEn = 3'b100;
    step(3'b100, 1'b0);
    step(3'b100, 1'b0);
    step(3'b100, 1'b0);
    intEn = '0;
    drain(3'b100, "R5");

    // R9: event on granted source in same cycle as its ack
    intEn = 3'b001;
    step(3'b001, 1'b0);
    step(3'b001, 1'b1);
    chk("R9 vector", vecOut, VBASE);
    chk("R9 valid", vecValid, 1);
    chk("R9 latch kept", irqOut, 1);
    step(3'b000, 1'b0);
    chk("R7 valid one cycle", vecValid, 0);
    intEn = '0;
    drain(3'b001, "R9");

    // R8: event on another source during ack of source 0
    intEn = 3'b111;
    step(3'b001, 1'b0);
    step(3'b100, 1'b1);
    chk("R8 vector", vecOut, VBASE);
    intEn = '0;
    drain(3'b100, "R8");

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule